// File: doc/BRIEF.md
# Bidirectional Serial-Fill Shift Register

A clocked register of parameterised width (default four bits) that on every rising clock edge does exactly one of three things: clears itself, takes a parallel word, or moves its contents one place toward the chosen end while a single serial bit fills the position left empty. No hold mode exists. While neither clear nor load is asserted, the register shifts on every edge. A direction input picks which end the serial bit enters at.

The choice follows a fixed order: clear wins over load, and load wins over shift. All controls are sampled only at the rising edge. The register value is visible on the output at all times.

Top module: `bidir_shreg`

## Requirements
- R1: The register changes only at a rising clock edge. Between edges, `q_o` stays constant whatever the inputs do.
- R2: With `clr_i`=1 at an edge, `q_o` becomes all zeros. This holds whatever `load_i`, `dir_left_i`, `ser_i` and `par_i` are.
- R3: With `clr_i`=0 and `load_i`=1 at an edge, `q_o` becomes `par_i`. The direction and serial inputs have no effect on the result.
- R4: With `clr_i`=0, `load_i`=0 and `dir_left_i`=1 at an edge, the register shifts left. The new value is the old bits [W-2:0] with `ser_i` appended at bit 0, and the old bit W-1 is dropped.
- R5: With `clr_i`=0, `load_i`=0 and `dir_left_i`=0 at an edge, the register shifts right. `ser_i` enters at bit W-1 above the old bits [W-1:1], and the old bit 0 is dropped.
- R6: No hold mode exists. With `clr_i` and `load_i` both low, the register shifts at every edge. After W consecutive shifts in one direction, the register holds exactly the last W serial bits that entered.
- R7: When `clr_i` and `load_i` are both asserted at the same edge, the clear takes effect and the parallel word is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_i | input | 1 | Synchronous clear, active high, highest priority |
| load_i | input | 1 | Parallel load, active high |
| dir_left_i | input | 1 | Shift direction: 1 = left (toward MSB), 0 = right |
| ser_i | input | 1 | Serial bit inserted at the vacated end |
| par_i | input | W (4) | Parallel load word |
| q_o | output | W (4) | Current register value |

## Verification
Clear and load are the two functions that can be requested at the same edge. The bench provokes this in two ways. It has directed cycles that set both with a nonzero parallel word on a nonzero register, and it has random cycles that assert each control with a fair probability. After each such edge the output must read zero. A separate check confirms that a following load-only edge then stores the word, so the discarded load left nothing behind.

// File: rtl/bidir_shreg_pkg.sv
package bidir_shreg_pkg;

    typedef enum logic [1:0] {
        OP_CLEAR = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHL   = 2'd2,
        OP_SHR   = 2'd3
    } shreg_op_e;

    typedef struct packed {
        logic clr;
        logic load;
        logic dir_left;
        logic ser;
    } shreg_ctrl_t;

    function automatic shreg_op_e pick_op(input shreg_ctrl_t c);
        if (c.clr)
            return OP_CLEAR;
        else if (c.load)
            return OP_LOAD;
        else if (c.dir_left)
            return OP_SHL;
        else
            return OP_SHR;
    endfunction

endpackage

// File: rtl/shreg_decode.sv
module shreg_decode
    import bidir_shreg_pkg::*;
(
    input  shreg_ctrl_t ctrl_i,
    output shreg_op_e   op_o
);
    always_comb op_o = pick_op(ctrl_i);
endmodule

// File: rtl/shreg_next.sv
module shreg_next
    import bidir_shreg_pkg::*;
#(
    parameter int W = 4
) (
    input  shreg_op_e    op_i,
    input  logic         ser_i,
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] par_i,
    output logic [W-1:0] nxt_o
);
    logic [W-1:0] shl, shr;

    // Each bit takes its lower or upper neighbour; the serial bit fills the vacated end.
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign shl[i] = ser_i;
        end else begin : g_lmid
            assign shl[i] = cur_i[i-1];
        end
        if (i == W-1) begin : g_msb
            assign shr[i] = ser_i;
        end else begin : g_rmid
            assign shr[i] = cur_i[i+1];
        end
    end

    always_comb begin
        unique case (op_i)
            OP_CLEAR: nxt_o = '0;
            OP_LOAD:  nxt_o = par_i;
            OP_SHL:   nxt_o = shl;
            default:  nxt_o = shr;
        endcase
    end
endmodule

// File: rtl/bidir_shreg.sv
module bidir_shreg
    import bidir_shreg_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr_i,
    input  logic         load_i,
    input  logic         dir_left_i,
    input  logic         ser_i,
    input  logic [W-1:0] par_i,
    output logic [W-1:0] q_o
);
    shreg_ctrl_t  ctrl;
    shreg_op_e    op;
    logic [W-1:0] nxt;
    logic [W-1:0] q_r;

    assign ctrl = '{clr: clr_i, load: load_i, dir_left: dir_left_i, ser: ser_i};

    shreg_decode u_dec (.ctrl_i(ctrl), .op_o(op));

    shreg_next #(.W(W)) u_nxt (
        .op_i (op),
        .ser_i(ctrl.ser),
        .cur_i(q_r),
        .par_i(par_i),
        .nxt_o(nxt)
    );

    always_ff @(posedge clk) q_r <= nxt;

    assign q_o = q_r;
endmodule

// File: rtl/bidir_shreg_chk.sv
module bidir_shreg_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         clr_i,
    input logic         load_i,
    input logic         dir_left_i,
    input logic         ser_i,
    input logic [W-1:0] par_i,
    input logic [W-1:0] q_o
);
    logic armed = 1'b0;
    always_ff @(posedge clk) armed <= 1'b1;

    p_clear_r2: assert property (@(posedge clk) disable iff (!armed)
        clr_i |=> (q_o == '0));

    p_clear_beats_load_r7: assert property (@(posedge clk) disable iff (!armed)
        (clr_i && load_i) |=> (q_o == '0));

    p_load_r3: assert property (@(posedge clk) disable iff (!armed)
        (!clr_i && load_i) |=> (q_o == $past(par_i)));

    p_shl_r4: assert property (@(posedge clk) disable iff (!armed)
        (!clr_i && !load_i && dir_left_i) |=>
            (q_o == {$past(q_o[W-2:0]), $past(ser_i)}));

    p_shr_r5: assert property (@(posedge clk) disable iff (!armed)
        (!clr_i && !load_i && !dir_left_i) |=>
            (q_o == {$past(ser_i), $past(q_o[W-1:1])}));
endmodule

bind bidir_shreg bidir_shreg_chk #(.W(W)) u_chk (.*);

// File: tb/bidir_shreg_test.sv
`timescale 1ns/1ps
module bidir_shreg_test;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         clr_i = 1'b0, load_i = 1'b0, dir_left_i = 1'b0, ser_i = 1'b0;
    logic [W-1:0] par_i = '0;
    logic [W-1:0] q_o;
    logic [W-1:0] model;
    int           errors = 0, checks = 0;
    bit           done = 0;

    always #2 clk = ~clk;

    bidir_shreg #(.W(W)) uut (.*);

    function automatic logic [W-1:0] ref_next(logic [W-1:0] cur, logic c, logic l,
                                              logic d, logic s, logic [W-1:0] p);
        if (c) return '0;
        if (l) return p;
        if (d) return {cur[W-2:0], s};
        return {s, cur[W-1:1]};
    endfunction

    task automatic check(string req, logic [W-1:0] exp);
        checks++;
        if (q_o !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, q_o, exp);
        end
    endtask

    // Inputs applied at the falling edge; one rising edge; sampled at the next falling edge.
    task automatic step(logic c, logic l, logic d, logic s, logic [W-1:0] p, string req);
        clr_i = c; load_i = l; dir_left_i = d; ser_i = s; par_i = p;
        model = ref_next(model, c, l, d, s, p);
        @(negedge clk);
        check(req, model);
    endtask

    initial begin
        @(negedge clk);
        model = 'x;
        step(1, 0, 0, 0, 4'hF, "R2 reset");
        step(0, 1, 1, 1, 4'hA, "R3 load");
        // R1: wiggle inputs mid-cycle, output must not move
        #0.5 clr_i = 1; par_i = 4'h5; load_i = 1; #0.5;
        check("R1 stable between edges", 4'hA);
        step(0, 0, 1, 0, 4'h0, "R4 shift left");   // 0100
        step(0, 0, 1, 1, 4'h0, "R4 shift left");   // 1001
        step(0, 0, 0, 1, 4'h0, "R5 shift right");  // 1100
        step(0, 0, 0, 0, 4'h0, "R5 shift right");  // 0110
        step(1, 1, 1, 1, 4'h9, "R7 clear beats load");
        step(0, 1, 0, 0, 4'h9, "R7 load after discarded load");
        step(1, 1, 0, 0, 4'h6, "R7 clear beats load");
        // R6: four left shifts of 1,0,1,1 leave 1011
        step(0, 1, 0, 0, 4'h6, "R3 load");
        step(0, 0, 1, 1, 4'h0, "R6 left fill");
        step(0, 0, 1, 0, 4'h0, "R6 left fill");
        step(0, 0, 1, 1, 4'h0, "R6 left fill");
        step(0, 0, 1, 1, 4'h0, "R6 left fill");
        check("R6 left fill holds serial bits", 4'b1011);
        // four right shifts of 1,1,0,1: last in at MSB -> 1011
        step(0, 0, 0, 1, 4'h0, "R6 right fill");
        step(0, 0, 0, 1, 4'h0, "R6 right fill");
        step(0, 0, 0, 0, 4'h0, "R6 right fill");
        step(0, 0, 0, 1, 4'h0, "R6 right fill");
        check("R6 right fill holds serial bits", 4'b1011);
        void'($urandom(32'd1234));
        for (int i = 0; i < 400; i++) begin
            logic c, l;
            c = ($urandom % 5) == 0;
            l = ($urandom % 3) == 0;
            step(c, l, 1'($urandom), 1'($urandom), W'($urandom),
                 c ? (l ? "R7 random" : "R2 random") : l ? "R3 random" : "R4/R5 random");
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule